// File: doc/BRIEF.md
# LFSR Stochastic Bitstream Encoder

This block turns an unsigned probability, given as a 16-bit two's-complement fixed-point number with eight fraction bits, into a serial stochastic bitstream. Every clock it emits one bit, and the long-run share of ones in that stream equals the probability. The random source is a 16-bit maximal-length linear feedback shift register for the polynomial x^16 + x^14 + x^13 + x^11 + 1. The low byte of its state is compared against the clamped input level.

The seed is fixed at elaboration as a base plus a stride times an instance index. A software model seeded the same way therefore reproduces the stream bit for bit and cycle for cycle. A start pulse reloads the seed to begin a new stream. A stream of L bits costs L clocks after the start pulse.

Top module: `sbs_encoder`

## Requirements
- R1: While reset is high at a rising edge, the output bit becomes 0 and the register takes the seed, so the first bit after reset is released is computed from the seed state.
- R2: Every cycle without start or reset, the register shifts right by one. The bit entering at position 15 is the XOR of state bits 0, 2, 3 and 5, which realises x^16 + x^14 + x^13 + x^11 + 1.
- R3: A start pulse sampled at an edge clears the output bit to 0 and reloads the seed at that edge. This holds even in the middle of a running stream. The next bit is computed from the seed state.
- R4: At each edge without start or reset, the output bit becomes 1 exactly when the 9-bit number {0, state[7:0]} is less than the clamped level of the value present in that cycle.
- R5: A value with bit 15 clear and a magnitude of 0x0100 or more clamps to level 256, which gives a steady 1.
- R6: The value 0x0000, or any value with bit 15 set (negative), clamps to level 0, which gives a steady 0.
- R7: The seed is BASE_SEED + SEED_STRIDE * INDEX modulo 2^16. A result of zero is replaced by 0x0001, so the register never holds zero.
- R8: Over 1024 consecutive bits at value 0x0080, the count of ones lies between 448 and 576.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Reloads the seed and begins a new stream |
| value | input | 16 | Probability, two's complement with 8 fraction bits |
| bit_o | output | 1 | Stochastic stream bit, one per clock |

## Verification
Two functions can coincide in one cycle: a start pulse and the normal shift-and-compare step. This is provoked by raising start partway through a stream while the value is at full scale. The bit after that edge must be 0, not the 1 that full scale would give, and the bits that follow must restart from the seed sequence of a bench model. The same pattern is repeated with reset and start raised together, and the outcome must be the same.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

    localparam int LFSR_W = 16;
    localparam int VAL_W  = 16;
    localparam int FRAC_W = 8;
    localparam int LVL_W  = FRAC_W + 1;

    // taps at bits 0,2,3,5 of a right-shifting register: x^16+x^14+x^13+x^11+1
    localparam logic [LFSR_W-1:0] TAP_MASK = 16'h002D;

    typedef logic [LFSR_W-1:0] lfsr_t;
    typedef logic [VAL_W-1:0]  q88_t;
    typedef logic [LVL_W-1:0]  level_t;

    localparam level_t FULL_LEVEL = level_t'(1 << FRAC_W);

    typedef struct packed {
        logic   neg;
        logic   over;
        level_t level;
    } clamp_t;

    function automatic lfsr_t lfsr_step(lfsr_t s);
        return {^(s & TAP_MASK), s[LFSR_W-1:1]};
    endfunction

    function automatic clamp_t clamp_q88(q88_t v);
        clamp_t c;
        c.neg  = v[VAL_W-1];
        c.over = !c.neg && (v > q88_t'(FULL_LEVEL));
        if (c.neg)
            c.level = '0;
        else if (c.over)
            c.level = FULL_LEVEL;
        else
            c.level = v[LVL_W-1:0];
        return c;
    endfunction

    function automatic lfsr_t seed_of(lfsr_t base, lfsr_t stride, int unsigned idx);
        lfsr_t s;
        s = base + stride * lfsr_t'(idx);
        return (s == '0) ? lfsr_t'(1) : s;
    endfunction

endpackage

// File: rtl/sbs_lfsr.sv
module sbs_lfsr
    import sbs_pkg::*;
#(
    parameter lfsr_t SEED = 16'hACE1
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    output lfsr_t state_o
);

    lfsr_t state_q;

    always_ff @(posedge clk) begin
        if (rst || load)
            state_q <= SEED;
        else
            state_q <= lfsr_step(state_q);
    end

    assign state_o = state_q;

    // assertion helper: one clean cycle seen after reset
    logic primed;
    always_ff @(posedge clk) begin
        if (rst) primed <= 1'b0;
        else     primed <= 1'b1;
    end

    p_seed_reload_r3: assert property (@(posedge clk) disable iff (rst)
        load |=> (state_q == SEED));

    p_right_shift_r2: assert property (@(posedge clk) disable iff (rst)
        (primed && !load) |=> (state_q[LFSR_W-2:0] == $past(state_q[LFSR_W-1:1])));

    p_state_nonzero_r7: assert property (@(posedge clk) disable iff (rst)
        primed |-> (state_q != '0));

endmodule

// File: rtl/sbs_compare.sv
module sbs_compare
    import sbs_pkg::*;
(
    input  lfsr_t state_i,
    input  q88_t  value_i,
    output logic  hit_o
);

    clamp_t cl;
    level_t sample;

    always_comb begin
        cl     = clamp_q88(value_i);
        sample = {1'b0, state_i[FRAC_W-1:0]};
        hit_o  = (sample < cl.level);
    end

    always_comb begin
        if (cl.neg)
            a_neg_level_r6: assert (cl.level == '0);
        if (cl.over)
            a_over_level_r5: assert (cl.level == FULL_LEVEL);
    end

endmodule

// File: rtl/sbs_encoder.sv
module sbs_encoder
    import sbs_pkg::*;
#(
    parameter logic [15:0] BASE_SEED   = 16'hACE1,
    parameter logic [15:0] SEED_STRIDE = 16'd7,
    parameter int unsigned INDEX       = 0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [15:0] value,
    output logic        bit_o
);

    localparam lfsr_t SEED = seed_of(BASE_SEED, SEED_STRIDE, INDEX);

    lfsr_t state;
    logic  hit;
    logic  bit_q;

    sbs_lfsr #(.SEED(SEED)) u_lfsr (
        .clk     (clk),
        .rst     (rst),
        .load    (start),
        .state_o (state)
    );

    sbs_compare u_cmp (
        .state_i (state),
        .value_i (value),
        .hit_o   (hit)
    );

    always_ff @(posedge clk) begin
        if (rst || start)
            bit_q <= 1'b0;
        else
            bit_q <= hit;
    end

    assign bit_o = bit_q;

    p_start_clears_r3: assert property (@(posedge clk) disable iff (rst)
        start |=> !bit_o);

    p_full_scale_one_r5: assert property (@(posedge clk) disable iff (rst)
        (!start && !value[15] && (value >= 16'h0100)) |=> bit_o);

    p_zero_scale_r6: assert property (@(posedge clk) disable iff (rst)
        (!start && (value[15] || (value == 16'h0000))) |=> !bit_o);

    p_reset_clears_r1: assert property (@(posedge clk)
        rst |=> !bit_o);

endmodule

// File: tb/sim_sbs_encoder.sv
module sim_sbs_encoder;

    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] value = 16'h0000;
    logic        bit0, bit1;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // seeds worked out from R7: 0xACE1 + 7*5, and 0 + 0*0 replaced by 1
    localparam logic [15:0] S0 = 16'hACE1 + 16'd35;
    localparam logic [15:0] S1 = 16'h0001;

    logic [15:0] m0, m1;

    // {value, clamped level}
    localparam logic [24:0] VEC [8] = '{
        {16'h0080, 9'd128},
        {16'h0100, 9'd256},
        {16'h7FFF, 9'd256},
        {16'hFF80, 9'd0},
        {16'h0000, 9'd0},
        {16'h0001, 9'd1},
        {16'h00FF, 9'd255},
        {16'h0140, 9'd256}
    };

    always #(PERIOD/2) clk = ~clk;

    sbs_encoder #(.BASE_SEED(16'hACE1), .SEED_STRIDE(16'd7), .INDEX(5)) u0 (
        .clk(clk), .rst(rst), .start(start), .value(value), .bit_o(bit0));

    sbs_encoder #(.BASE_SEED(16'h0000), .SEED_STRIDE(16'd0), .INDEX(0)) u1 (
        .clk(clk), .rst(rst), .start(start), .value(value), .bit_o(bit1));

    function automatic logic [15:0] nxt(logic [15:0] s);
        return {s[0] ^ s[2] ^ s[3] ^ s[5], s[15:1]};
    endfunction

    task automatic check(input logic act, input logic exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    // called at a falling edge; compares after the next rising edge
    task automatic step(input logic st, input logic [15:0] v, input logic [8:0] lvl,
                        input string req);
        logic e0, e1;
        start = st;
        value = v;
        e0 = st ? 1'b0 : ({1'b0, m0[7:0]} < lvl);
        e1 = st ? 1'b0 : ({1'b0, m1[7:0]} < lvl);
        m0 = st ? S0 : nxt(m0);
        m1 = st ? S1 : nxt(m1);
        @(posedge clk);
        @(negedge clk);
        check(bit0, e0, req);
        check(bit1, e1, req);
    endtask

    task automatic do_reset(input logic with_start);
        rst = 1'b1;
        start = with_start;
        value = 16'h0100;
        @(posedge clk);
        @(negedge clk);
        check(bit0, 1'b0, "R1 reset output");
        check(bit1, 1'b0, "R1 reset output");
        m0 = S0;
        m1 = S1;
        rst = 1'b0;
        start = 1'b0;
    endtask

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int ones;
        @(negedge clk);
        do_reset(1'b0);
        do_reset(1'b0);

        // R1: first bits after reset come from the seed
        for (int k = 0; k < 4; k++) step(1'b0, 16'h0080, 9'd128, "R1 post-reset sequence");

        // table walk; start on the first entry (R3), sequence per R2/R4
        for (int i = 0; i < 8; i++) begin
            for (int c = 0; c < 32; c++) begin
                step((i == 0 && c == 0), VEC[i][24:9], VEC[i][8:0],
                     (VEC[i][8:0] == 9'd256) ? "R5 full scale" :
                     (VEC[i][8:0] == 9'd0)   ? "R6 zero/negative" : "R4 R2 compare");
            end
        end

        // R3: start in the middle of a full-scale stream wins over the shift step
        for (int k = 0; k < 5; k++) step(1'b0, 16'h0100, 9'd256, "R5 full scale");
        step(1'b1, 16'h0100, 9'd256, "R3 start mid-stream");
        for (int k = 0; k < 6; k++) step(1'b0, 16'h0090, 9'd144, "R3 restart sequence");

        // R1 with start together
        do_reset(1'b1);
        for (int k = 0; k < 6; k++) step(1'b0, 16'h0040, 9'd64, "R1 reset+start");

        // R7: zero seed replaced by 1 on u1
        step(1'b1, 16'h0002, 9'd2, "R3 start");
        step(1'b0, 16'h0002, 9'd2, "R7 seed one");
        step(1'b0, 16'h0001, 9'd1, "R7 seed one next");
        for (int k = 0; k < 40; k++) step(1'b0, 16'h00C0, 9'd192, "R7 R2 sequence");

        // R8: density at one half
        step(1'b1, 16'h0080, 9'd128, "R3 start");
        ones = 0;
        for (int k = 0; k < 1024; k++) begin
            step(1'b0, 16'h0080, 9'd128, "R8 R4 stream");
            ones += int'(bit0);
        end
        n_chk++;
        if (ones < 448 || ones > 576) begin
            n_fail++;
            $display("FAIL R8 density: got %0d expected 448..576", ones);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule